// File: doc/BRIEF.md
# Serial NOR Flash Storage Array Engine

This block is the storage array that sits behind a serial NOR flash front end. It holds a byte array, sized by parameter, that comes up erased (every byte 0xFF) and keeps its contents across reset, as a non-volatile store would. A command decoder drives one request at a time into it: a byte read, a byte program, or one of four erases (4 KiB, 32 KiB, one sector, or the whole array). Each request carries a start address.

Programming follows NOR rules. A program can only pull bits from 1 to 0 unless the part's overwrite capability input is high. Every program and erase is gated by a write-enable level that the front end keeps. An erase sweeps the array one byte per clock with `busy` high. Requests that arrive while `busy` is high are dropped. The part's capability inputs say which of the two fixed erase sizes it supports. An erase size the part does not support raises a one-cycle error pulse, and the erase is still carried out.

The array size must be a power of two. An erase that starts near the top of the array wraps around to address 0. An erase is never longer than the array.

Top module: `flash_array_engine`

## Requirements
- R1: After power-up every byte reads 0xFF. While reset is high and in the cycle after it, `busy`, `rd_valid`, `err_protect` and `err_size` are low.
- R2: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. A read (`req_op` = 0) raises `rd_valid` for exactly the cycle after the accepting edge, with the addressed byte on `rd_data`.
- R3: A program (`req_op` = 1) with `wr_en` high and `cap_overwrite` low stores the old byte AND `req_data`. `busy` is high for exactly the one cycle after the accepting edge.
- R4: A program with `wr_en` high and `cap_overwrite` high stores `req_data` unchanged, so bits can go from 0 back to 1.
- R5: A program with `wr_en` low leaves the byte unchanged. `err_protect` is high for the one cycle after the accepting edge.
- R6: A 4 KiB erase (`req_op` = 2) sets min(4096, ARRAY_BYTES) bytes to 0xFF, starting at `req_addr` with no alignment and wrapping at the top of the array. `busy` is high for exactly that many cycles, and bytes outside the range keep their values.
- R7: A 32 KiB erase (`req_op` = 3) works like R6 with a length of min(32768, ARRAY_BYTES) bytes.
- R8: A sector erase (`req_op` = 4) works like R6 with a length of SECTOR_BYTES, the part's own parameter.
- R9: A whole-array erase (`req_op` = 5) ignores `req_addr`, starts at 0 and sets every byte to 0xFF, with `busy` high for ARRAY_BYTES cycles.
- R10: Any erase with `wr_en` low changes no byte and leaves `busy` low. `err_protect` pulses for the one cycle after the accepting edge.
- R11: A 4 KiB erase with `cap_4k` low, or a 32 KiB erase with `cap_32k` low, pulses `err_size` for the one cycle after the accepting edge and still performs the erase. Other ops never raise `err_size`.
- R12: While `busy` is high, requests have no effect: no `rd_valid`, no error pulse, no array change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (array contents kept) |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | 0 read, 1 program, 2 erase 4 KiB, 3 erase 32 KiB, 4 erase sector, 5 erase all; 6 and 7 do nothing |
| req_addr | input | $clog2(ARRAY_BYTES) | Byte address or erase start |
| req_data | input | 8 | Program data |
| wr_en | input | 1 | Write-enable level from the front end |
| cap_4k | input | 1 | Part supports the 4 KiB erase |
| cap_32k | input | 1 | Part supports the 32 KiB erase |
| cap_overwrite | input | 1 | Program stores data directly instead of ANDing |
| busy | output | 1 | Program or erase in progress; requests ignored |
| rd_valid | output | 1 | `rd_data` holds the byte of an accepted read |
| rd_data | output | 8 | Read byte |
| err_protect | output | 1 | One-cycle pulse: program or erase refused by write enable |
| err_size | output | 1 | One-cycle pulse: erase size not supported by the part |

## Verification
Every result is due a fixed number of edges after the accepting edge. Read data, `rd_valid` and both error pulses appear one edge later. A program holds `busy` for one cycle, and an erase holds it for as many cycles as it has bytes. The bench drives each request on a falling edge and drops it on the next falling edge, which falls just after the accepting rising edge, so the one-edge results are sampled there. For erases, the bench counts the falling edges at which `busy` is seen high and compares that count with the expected length. It also injects requests mid-sweep and checks at the next falling edge that nothing answered them.

// File: rtl/flash_eng_pkg.sv
`timescale 1ns/1ps
package flash_eng_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_PROG    = 3'd1,
    OP_ER_4K   = 3'd2,
    OP_ER_32K  = 3'd3,
    OP_ER_SECT = 3'd4,
    OP_ER_ALL  = 3'd5
  } fe_op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_byte_mem.sv
`timescale 1ns/1ps
// Simple dual-port byte store with registered read, shaped for block RAM.
module flash_byte_mem #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_q,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data
);
  logic [7:0] cells [DEPTH];

  // Power-up image: erased
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = flash_eng_pkg::ERASED_BYTE;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
    if (rd_en) rd_q <= cells[rd_addr];
  end
endmodule

// File: rtl/flash_erase_sweep.sv
`timescale 1ns/1ps
// Walks an address range one byte per clock, wrapping at the array top.
module flash_erase_sweep #(
  parameter int AW = 11,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  output logic          active,
  output logic [AW-1:0] cur_addr
);
  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      left     <= '0;
      cur_addr <= '0;
    end else if (start) begin
      active   <= (start_len != '0);
      left     <= start_len;
      cur_addr <= start_addr;
    end else if (active) begin
      cur_addr <= cur_addr + 1'b1;
      left     <= left - 1'b1;
      if (left == LW'(1)) active <= 1'b0;
    end
  end

  AST_SWEEP_END_COUNT: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> ($past(left) == LW'(1))); // R6
  AST_SWEEP_LEFT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    active |-> (left != '0)); // R6
endmodule

// File: rtl/flash_array_engine.sv
`timescale 1ns/1ps
module flash_array_engine #(
  parameter int ARRAY_BYTES       = 2048,
  parameter int SECTOR_BYTES      = 512,
  parameter int SMALL_ERASE_BYTES = 4096,
  parameter int MID_ERASE_BYTES   = 32768,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          wr_en,
  input  logic          cap_4k,
  input  logic          cap_32k,
  input  logic          cap_overwrite,
  output logic          busy,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          err_protect,
  output logic          err_size
);
  import flash_eng_pkg::*;

  localparam int LW = $clog2(ARRAY_BYTES + 1);
  localparam logic [LW-1:0] LEN_SMALL =
    LW'((SMALL_ERASE_BYTES < ARRAY_BYTES) ? SMALL_ERASE_BYTES : ARRAY_BYTES);
  localparam logic [LW-1:0] LEN_MID =
    LW'((MID_ERASE_BYTES < ARRAY_BYTES) ? MID_ERASE_BYTES : ARRAY_BYTES);
  localparam logic [LW-1:0] LEN_SECT =
    LW'((SECTOR_BYTES < ARRAY_BYTES) ? SECTOR_BYTES : ARRAY_BYTES);
  localparam logic [LW-1:0] LEN_ALL = LW'(ARRAY_BYTES);

  // Request decode
  logic          accept, is_read, is_prog, is_erase;
  logic          er_start;
  logic [LW-1:0] er_len;
  logic [AW-1:0] er_base;

  // Program pipeline
  logic          pg_pend;
  logic [AW-1:0] pg_addr;
  logic [7:0]    pg_data;

  // Sweep and memory wiring
  logic          er_active;
  logic [AW-1:0] er_addr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_q;

  assign busy     = er_active | pg_pend;
  assign accept   = req_valid & ~busy;
  assign is_read  = (req_op == OP_READ);
  assign is_prog  = (req_op == OP_PROG);
  assign is_erase = (req_op == OP_ER_4K) || (req_op == OP_ER_32K) ||
                    (req_op == OP_ER_SECT) || (req_op == OP_ER_ALL);
  assign er_start = accept & is_erase & wr_en;
  assign er_base  = (req_op == OP_ER_ALL) ? '0 : req_addr;

  always_comb begin
    case (req_op)
      OP_ER_4K:   er_len = LEN_SMALL;
      OP_ER_32K:  er_len = LEN_MID;
      OP_ER_SECT: er_len = LEN_SECT;
      default:    er_len = LEN_ALL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_pend     <= 1'b0;
      pg_addr     <= '0;
      pg_data     <= '0;
      rd_valid    <= 1'b0;
      err_protect <= 1'b0;
      err_size    <= 1'b0;
    end else begin
      pg_pend     <= accept & is_prog & wr_en;
      rd_valid    <= accept & is_read;
      err_protect <= accept & ~wr_en & (is_prog | is_erase);
      err_size    <= accept & (((req_op == OP_ER_4K) & ~cap_4k) |
                               ((req_op == OP_ER_32K) & ~cap_32k));
      if (accept & is_prog) begin
        pg_addr <= req_addr;
        pg_data <= req_data;
      end
    end
  end

  // Write port: sweep has the port while active, else the pending program
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = pg_addr;
    mem_wdata = cap_overwrite ? pg_data : (mem_q & pg_data);
    if (er_active) begin
      mem_we    = 1'b1;
      mem_waddr = er_addr;
      mem_wdata = ERASED_BYTE;
    end else if (pg_pend) begin
      mem_we    = 1'b1;
    end
  end

  flash_erase_sweep #(.AW(AW), .LW(LW)) u_sweep (
    .clk        (clk),
    .rst        (rst),
    .start      (er_start),
    .start_addr (er_base),
    .start_len  (er_len),
    .active     (er_active),
    .cur_addr   (er_addr)
  );

  flash_byte_mem #(.DEPTH(ARRAY_BYTES), .AW(AW)) u_mem (
    .clk     (clk),
    .rd_en   (accept & (is_read | is_prog)),
    .rd_addr (req_addr),
    .rd_q    (mem_q),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata)
  );

  assign rd_data = mem_q;

  AST_RD_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !busy && req_op == OP_READ)); // R2
  AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pg_pend |=> !pg_pend); // R3
  AST_ERASE_NEEDS_WE: assert property (@(posedge clk) disable iff (rst)
    $rose(er_active) |-> $past(wr_en)); // R10
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> (!rd_valid && !err_protect && !err_size)); // R12
  AST_SIZE_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    err_size |-> $past(req_op == OP_ER_4K || req_op == OP_ER_32K)); // R11
endmodule

// File: tb/tb_flash_array_engine.sv
`timescale 1ns/1ps
module tb_flash_array_engine;
  import flash_eng_pkg::*;

  localparam int NB = 8192;
  localparam int SB = 1024;
  localparam int AW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = 8'h00;
  logic          wr_en = 1'b0, cap_4k = 1'b1, cap_32k = 1'b1, cap_overwrite = 1'b0;
  logic          busy, rd_valid, err_protect, err_size;
  logic [7:0]    rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_array_engine #(.ARRAY_BYTES(NB), .SECTOR_BYTES(SB)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en),
    .cap_4k(cap_4k), .cap_32k(cap_32k), .cap_overwrite(cap_overwrite),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_protect(err_protect), .err_size(err_size)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one request; returns at the falling edge just after acceptance
  task automatic send(input logic [2:0] op, input int a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_byte(input int a, input logic [7:0] e, input string tag);
    send(OP_READ, a, 8'h00);
    chk(rd_valid === 1'b1, {tag, " R2 rd_valid"}, rd_valid, 1);
    chk(rd_data === e, tag, rd_data, e);
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    send(OP_PROG, a, d);
    while (busy) @(negedge clk);
  endtask

  // Erase and count busy cycles; optional mid-sweep interference
  task automatic erase(input logic [2:0] op, input int a, input bit poke,
                       input int poke_addr, output int cyc);
    send(op, a, 8'h00);
    cyc = 0;
    while (busy) begin
      cyc++;
      if (poke) begin
        if (cyc == 11) chk(rd_valid === 1'b0, "R12 read during busy", rd_valid, 0);
        if (cyc == 12) chk(err_protect === 1'b0, "R12 no pulse during busy", err_protect, 0);
        req_valid = (cyc == 10) || (cyc == 11);
        req_op    = (cyc == 10) ? OP_READ : OP_PROG;
        req_addr  = AW'(poke_addr);
        req_data  = 8'h00;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(rd_valid === 1'b0, "R1 rd_valid after reset", rd_valid, 0);
    chk(err_protect === 1'b0 && err_size === 1'b0, "R1 errors after reset",
        {err_protect, err_size}, 0);
    expect_byte(0, 8'hFF, "R1 erased byte 0");
    expect_byte(NB - 1, 8'hFF, "R1 erased top byte");
    expect_byte(1234, 8'hFF, "R1 erased mid byte");
  endtask

  task automatic t_program;
    wr_en = 1'b1; cap_overwrite = 1'b0;
    send(OP_PROG, 10, 8'hA5);
    chk(busy === 1'b1, "R3 busy one cycle", busy, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R3 busy released", busy, 0);
    expect_byte(10, 8'hA5, "R3 program erased byte");
    prog(10, 8'h0F);
    expect_byte(10, 8'h05, "R3 AND with old byte");
    prog(11, 8'h3C);
    expect_byte(11, 8'h3C, "R2 read of neighbour");
  endtask

  task automatic t_overwrite;
    cap_overwrite = 1'b1;
    prog(10, 8'hF0);
    expect_byte(10, 8'hF0, "R4 overwrite sets bits");
    cap_overwrite = 1'b0;
  endtask

  task automatic t_protect;
    int c;
    wr_en = 1'b0;
    send(OP_PROG, 10, 8'h00);
    chk(err_protect === 1'b1, "R5 err_protect on program", err_protect, 1);
    while (busy) @(negedge clk);
    expect_byte(10, 8'hF0, "R5 byte kept");
    erase(OP_ER_4K, 0, 1'b0, 0, c);
    chk(c == 0, "R10 no busy when protected", c, 0);
    expect_byte(10, 8'hF0, "R10 array unchanged");
    wr_en = 1'b1;
  endtask

  task automatic t_erase_small;
    int c;
    prog(99, 8'h00); prog(100, 8'h00); prog(4195, 8'h00); prog(4196, 8'h00);
    erase(OP_ER_4K, 100, 1'b1, 5000, c);
    chk(c == 4096, "R6 busy length", c, 4096);
    expect_byte(99, 8'h00, "R6 below range kept");
    expect_byte(100, 8'hFF, "R6 first byte erased");
    expect_byte(4195, 8'hFF, "R6 last byte erased");
    expect_byte(4196, 8'h00, "R6 above range kept");
    expect_byte(5000, 8'hFF, "R12 program during busy dropped");
    // Wrap past the top
    prog(1903, 8'h00); prog(1904, 8'h00); prog(5999, 8'h00);
    erase(OP_ER_4K, 6000, 1'b0, 0, c);
    chk(c == 4096, "R6 wrap busy length", c, 4096);
    expect_byte(1903, 8'hFF, "R6 wrapped byte erased");
    expect_byte(1904, 8'h00, "R6 after wrap kept");
    expect_byte(5999, 8'h00, "R6 before start kept");
  endtask

  task automatic t_erase_mid;
    int c;
    cap_32k = 1'b0;
    prog(0, 8'h00); prog(3000, 8'h00); prog(NB - 1, 8'h00);
    send(OP_ER_32K, 300, 8'h00);
    chk(err_size === 1'b1, "R11 err_size on unsupported size", err_size, 1);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    chk(c == NB, "R7 clipped length", c, NB);
    expect_byte(0, 8'hFF, "R7 R11 erased anyway");
    expect_byte(3000, 8'hFF, "R7 mid erased");
    expect_byte(NB - 1, 8'hFF, "R7 top erased");
    cap_32k = 1'b1;
  endtask

  task automatic t_sector;
    int c;
    prog(1999, 8'h00); prog(2000, 8'h00); prog(3023, 8'h00); prog(3024, 8'h00);
    send(OP_ER_SECT, 2000, 8'h00);
    chk(err_size === 1'b0, "R11 no err_size on sector", err_size, 0);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    chk(c == SB, "R8 sector length", c, SB);
    expect_byte(1999, 8'h00, "R8 below kept");
    expect_byte(2000, 8'hFF, "R8 first erased");
    expect_byte(3023, 8'hFF, "R8 last erased");
    expect_byte(3024, 8'h00, "R8 above kept");
  endtask

  task automatic t_bulk;
    int c;
    cap_4k = 1'b0; cap_32k = 1'b0;
    prog(0, 8'h00); prog(7000, 8'h00); prog(4999, 8'h00);
    send(OP_ER_ALL, 5000, 8'h00);
    chk(err_size === 1'b0, "R11 no err_size on bulk", err_size, 0);
    c = 0;
    while (busy) begin c++; @(negedge clk); end
    chk(c == NB, "R9 bulk length", c, NB);
    expect_byte(0, 8'hFF, "R9 offset 0 erased");
    expect_byte(4999, 8'hFF, "R9 below given addr erased");
    expect_byte(7000, 8'hFF, "R9 high erased");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_overwrite();
    t_protect();
    t_erase_small();
    t_erase_mid();
    t_sector();
    t_bulk();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule